// File: doc/BRIEF.md
# Destination Address Receive Filter with Multicast Hash

This block sits on the receive path of an Ethernet MAC and decides whether an incoming frame should be kept, judging only by its 48-bit destination address. The address arrives one octet per cycle, first octet first, with a start marker on the first octet. While the octets stream in, the block collects the address and runs a CRC-32 over it. One cycle after the sixth octet it issues a single-cycle decision strobe with an accept flag and the 6-bit hash index it derived.

A frame is kept when it matches the programmed station address, when it is the all-ones broadcast address, or when it is a group address whose hash bit is set in a 64-bit table. Each of these three paths has its own enable. A fourth control, promiscuous mode, keeps every frame and treats every table bit as set. The station address is written through two word-wide load strobes. The table arrives as two 32-bit configuration words.

Top module: `mhf_rx_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are low and the stored station address is all zeros, so a zero destination address matches it when `cfg_phys_en` is set.
- R2: A pulse on `sta_we_lo` stores `sta_wdata[7:0]` as address octet 0, `[15:8]` as octet 1, `[23:16]` as octet 2 and `[31:24]` as octet 3. A pulse on `sta_we_hi` stores `sta_wdata[7:0]` as octet 4 and `[15:8]` as octet 5 and ignores `sta_wdata[31:16]`. Each strobe changes only its own octets.
- R3: An octet with `in_valid` and `in_sof` both high becomes address octet 0, and the next five octets with `in_valid` high and `in_sof` low fill octets 1 to 5. Further octets without `in_sof` are ignored. An `in_sof` octet in the middle of an address restarts collection.
- R4: `dec_valid` is high for exactly one cycle, in the cycle after the sixth address octet is taken. `dec_accept` and `dec_hash` are zero whenever `dec_valid` is low.
- R5: `dec_hash` equals bits 31:26 of a CRC-32 with polynomial 0x04C11DB7, seeded with all ones and not inverted. The CRC is shifted most significant bit first and is fed octets 0 to 5 in order, each octet least significant bit first.
- R6: A hash index below 32 selects bit `index` of `hash_lo`, and an index of 32 or more selects bit `index-32` of `hash_hi`.
- R7: An address equal to the station address is accepted when `cfg_phys_en` is high.
- R8: The address with all 48 bits set is accepted when `cfg_bcast_en` is high.
- R9: An address is a group address when bit 0 of octet 0 is set, which includes broadcast. A group address is accepted through the hash path only when `cfg_mcast_en` is high and its selected table bit is 1.
- R10: With `cfg_promisc` high every address is accepted, and the effective table is all ones whatever `hash_lo` and `hash_hi` hold.
- R11: With `cfg_promisc` low, an address is rejected unless one of the three enabled paths (R7, R8, R9) applies. This covers a non-matching individual address even when all three enables are set and the table is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Octet on `in_byte` is present this cycle |
| in_sof | input | 1 | Marks the first octet of a frame |
| in_byte | input | 8 | Received octet |
| sta_we_lo | input | 1 | Load station octets 0 to 3 from `sta_wdata` |
| sta_we_hi | input | 1 | Load station octets 4 and 5 from `sta_wdata[15:0]` |
| sta_wdata | input | 32 | Station address load data |
| cfg_phys_en | input | 1 | Enable the station-match path |
| cfg_bcast_en | input | 1 | Enable the broadcast path |
| cfg_mcast_en | input | 1 | Enable the hashed group-address path |
| cfg_promisc | input | 1 | Accept all frames |
| hash_lo | input | 32 | Hash table bits 0 to 31 |
| hash_hi | input | 32 | Hash table bits 32 to 63 |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Frame is kept (qualified by `dec_valid`) |
| dec_hash | output | 6 | Hash index of the collected address |

## Verification
The bench sends individual addresses that match the station address and others that differ from it in only the upper word, the broadcast address, and group addresses chosen so that their hash falls in the low table word or in the high one. Each of these is sent with a single enable set, with all enables set and with promiscuous mode set. A one-hot table and its complement separate a correct index and word selection from neighbouring bits. A zero table or a full table separates the hash path from the broadcast and station paths. Interrupted and overlong octet sequences show which octets form the address, and a recomputed CRC checks every reported hash index.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int unsigned OCT_W      = 8;
    localparam int unsigned CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    // Collector state: octet counter, address shift image, done pulse.
    typedef struct packed {
        logic [3:0]  cnt;
        logic [47:0] addr;
        logic        done;
    } coll_state_t;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_state_t;

endpackage

// File: rtl/mhf_crc32_be.sv
module mhf_crc32_be
    import mhf_pkg::*;
#(
    parameter int unsigned HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [OCT_W-1:0]  byte_in,
    output logic [HASH_W-1:0] hash
);

    crc_state_t s_d, s_q;

    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] chain [0:OCT_W];

    assign base     = restart ? CRC_SEED : s_q.crc;
    assign chain[0] = base;

    // One shift stage per octet bit, least significant data bit first.
    for (genvar i = 0; i < OCT_W; i++) begin : g_bit
        logic fb;
        assign fb = chain[i][CRC_W-1] ^ byte_in[i];
        assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    always_comb begin
        s_d = s_q;
        if (step) begin
            s_d.crc = chain[OCT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.crc <= CRC_SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign hash = s_q.crc[CRC_W-1 -: HASH_W];

    // A restart without an octet would leave a stale CRC behind.
    AST_RESTART_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> step) else $error("restart without step"); // R5

endmodule

// File: rtl/mhf_addr_collect.sv
module mhf_addr_collect
    import mhf_pkg::*;
#(
    parameter int unsigned OCTETS = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [OCT_W-1:0]        in_byte,
    output logic [OCTETS*OCT_W-1:0] addr,
    output logic                    crc_restart,
    output logic                    crc_step,
    output logic                    done
);

    localparam int unsigned ADDR_W = OCTETS * OCT_W;
    localparam int unsigned CNT_W  = $clog2(OCTETS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OCTETS);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } state_t;

    state_t s_d, s_q;
    logic take_first;
    logic take_next;

    always_comb begin
        take_first = in_valid && in_sof;
        take_next  = in_valid && !in_sof && (s_q.cnt < CNT_FULL);
        s_d        = s_q;
        s_d.done   = 1'b0;
        if (take_first) begin
            s_d.addr            = '0;
            s_d.addr[OCT_W-1:0] = in_byte;
            s_d.cnt             = CNT_W'(1);
        end else if (take_next) begin
            s_d.addr[int'(s_q.cnt)*OCT_W +: OCT_W] = in_byte;
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
        s_d.done = (take_first || take_next) && (s_d.cnt == CNT_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= CNT_FULL;
            s_q.addr <= '0;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr        = s_q.addr;
    assign done        = s_q.done;
    assign crc_restart = take_first;
    assign crc_step    = take_first || take_next;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) && (s_q.cnt <= CNT_FULL)) else $error("octet counter out of range"); // R3

    AST_DONE_FOLLOWS_OCTET: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(in_valid)) else $error("done without octet"); // R4

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_FULL) && !(in_valid && in_sof) |=> $stable(s_q.addr)) else $error("address changed while idle"); // R3

endmodule

// File: rtl/mhf_station_addr.sv
module mhf_station_addr
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] station
);

    localparam int unsigned HI_W = ADDR_W - WORD_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [WORD_W-1:0] lo;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_lo) begin
            s_d.lo = wdata;
        end
        if (we_hi) begin
            s_d.hi = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign station = {s_q.hi, s_q.lo};

    AST_LO_LOAD_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo && !we_hi |=> $stable(station[ADDR_W-1:WORD_W])) else $error("low load touched high octets"); // R2

    AST_HI_LOAD_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi && !we_lo |=> $stable(station[WORD_W-1:0])) else $error("high load touched low octets"); // R2

endmodule

// File: rtl/mhf_rx_filter.sv
module mhf_rx_filter
    import mhf_pkg::*;
#(
    parameter int unsigned OCTETS = 6,
    parameter int unsigned HASH_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic [7:0]            in_byte,
    input  logic                  sta_we_lo,
    input  logic                  sta_we_hi,
    input  logic [31:0]           sta_wdata,
    input  logic                  cfg_phys_en,
    input  logic                  cfg_bcast_en,
    input  logic                  cfg_mcast_en,
    input  logic                  cfg_promisc,
    input  logic [31:0]           hash_lo,
    input  logic [31:0]           hash_hi,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic [HASH_W-1:0]     dec_hash
);

    localparam int unsigned ADDR_W = OCTETS * OCT_W;
    localparam int unsigned TBL_W  = 2 ** HASH_W;

    logic [ADDR_W-1:0] rx_addr;
    logic [ADDR_W-1:0] station;
    logic [HASH_W-1:0] hash_idx;
    logic              crc_restart;
    logic              crc_step;
    logic              addr_done;

    logic [TBL_W-1:0]  table_eff;
    logic              is_group;
    logic              is_bcast;
    logic              is_station;
    logic              hash_hit;
    logic              keep;

    mhf_addr_collect #(.OCTETS(OCTETS)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sof      (in_sof),
        .in_byte     (in_byte),
        .addr        (rx_addr),
        .crc_restart (crc_restart),
        .crc_step    (crc_step),
        .done        (addr_done)
    );

    mhf_crc32_be #(.HASH_W(HASH_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (crc_restart),
        .step    (crc_step),
        .byte_in (in_byte),
        .hash    (hash_idx)
    );

    mhf_station_addr #(.ADDR_W(ADDR_W), .WORD_W(32)) u_station (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_lo   (sta_we_lo),
        .we_hi   (sta_we_hi),
        .wdata   (sta_wdata),
        .station (station)
    );

    always_comb begin
        table_eff  = cfg_promisc ? '1 : {hash_hi, hash_lo};
        is_group   = rx_addr[0];
        is_bcast   = &rx_addr;
        is_station = (rx_addr == station);
        hash_hit   = table_eff[hash_idx];
        keep       = cfg_promisc
                   || (cfg_phys_en  && is_station)
                   || (cfg_bcast_en && is_bcast)
                   || (cfg_mcast_en && is_group && hash_hit);
        dec_valid  = addr_done;
        dec_accept = addr_done && keep;
        dec_hash   = addr_done ? hash_idx : '0;
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid) else $error("strobe longer than one cycle"); // R4

    AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && cfg_promisc |-> dec_accept) else $error("promiscuous reject"); // R10

    AST_NO_PATH_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !cfg_promisc && !cfg_phys_en && !cfg_bcast_en && !cfg_mcast_en |-> !dec_accept) else $error("accept with all paths off"); // R11

    AST_UNICAST_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept && !cfg_promisc && !rx_addr[0] |-> (rx_addr == station)) else $error("individual address accepted without match"); // R7

endmodule

// File: tb/sim_mhf_rx_filter.sv
module sim_mhf_rx_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        sta_we_lo = 1'b0;
    logic        sta_we_hi = 1'b0;
    logic [31:0] sta_wdata = '0;
    logic        cfg_phys_en = 1'b0;
    logic        cfg_bcast_en = 1'b0;
    logic        cfg_mcast_en = 1'b0;
    logic        cfg_promisc = 1'b0;
    logic [31:0] hash_lo = '0;
    logic [31:0] hash_hi = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [5:0]  dec_hash;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mhf_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
        .sta_we_lo(sta_we_lo), .sta_we_hi(sta_we_hi), .sta_wdata(sta_wdata),
        .cfg_phys_en(cfg_phys_en), .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_en(cfg_mcast_en),
        .cfg_promisc(cfg_promisc), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hash(dec_hash)
    );

    // Reference hash: octet k is mac[8k+7:8k], fed LSB first into an MSB-first CRC.
    function automatic logic [5:0] ref_hash(input logic [47:0] mac);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[31] ^ mac[8*k + j];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[31:26];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic p, input logic b, input logic m, input logic pr,
                           input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        cfg_phys_en = p; cfg_bcast_en = b; cfg_mcast_en = m; cfg_promisc = pr;
        hash_lo = lo; hash_hi = hi;
    endtask

    task automatic push(input logic [7:0] b, input logic sof);
        @(negedge clk);
        check("R4 no strobe mid-address", {31'd0, dec_valid}, 32'd0);
        in_valid = 1'b1; in_sof = sof; in_byte = b;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_byte = '0;
    endtask

    // Sends an address and checks strobe, accept and hash in the cycle after octet 5.
    task automatic send_addr(input logic [47:0] mac, input logic exp_acc, input string req);
        for (int k = 0; k < 6; k++) push(mac[8*k +: 8], k == 0);
        idle_cycle();
        check({req, " strobe"}, {31'd0, dec_valid}, 32'd1);
        check({req, " accept"}, {31'd0, dec_accept}, {31'd0, exp_acc});
        check("R5 hash index", {26'd0, dec_hash}, {26'd0, ref_hash(mac)});
        @(negedge clk);
        check("R4 strobe single cycle", {31'd0, dec_valid}, 32'd0);
        check("R4 accept idle low", {31'd0, dec_accept}, 32'd0);
    endtask

    task automatic load_station(input logic [47:0] mac);
        @(negedge clk);
        sta_we_lo = 1'b1; sta_wdata = mac[31:0];
        @(negedge clk);
        sta_we_lo = 1'b0; sta_we_hi = 1'b1; sta_wdata = {16'hA5C3, mac[47:32]};
        @(negedge clk);
        sta_we_hi = 1'b0; sta_wdata = '0;
    endtask

    task automatic find_group(input bit want_hi, output logic [47:0] mac);
        mac = '0;
        for (int k = 0; k < 256; k++) begin
            logic [47:0] cand;
            cand = {8'(k), 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
            if ((ref_hash(cand) >= 6'd32) == want_hi) begin
                mac = cand;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check("R1 reset strobe", {31'd0, dec_valid}, 32'd0);
        check("R1 reset accept", {31'd0, dec_accept}, 32'd0);
        set_cfg(1, 0, 0, 0, '0, '0);
        send_addr(48'h0, 1'b1, "R1 zero station after reset");
    endtask

    task automatic t_station();
        logic [47:0] st;
        st = 48'h66_55_44_33_22_10;
        load_station(st);
        set_cfg(1, 0, 0, 0, '0, '0);
        send_addr(st, 1'b1, "R7 station match");
        send_addr(48'h67_55_44_33_22_10, 1'b0, "R2 octet 5 differs");
        set_cfg(0, 1, 1, 0, '1, '1);
        send_addr(st, 1'b0, "R7 match with path disabled");
        // Rewrite only the high word; the low octets must survive.
        @(negedge clk);
        sta_we_hi = 1'b1; sta_wdata = 32'hFFFF_9988;
        @(negedge clk);
        sta_we_hi = 1'b0;
        set_cfg(1, 0, 0, 0, '0, '0);
        send_addr(48'h99_88_44_33_22_10, 1'b1, "R2 high-only rewrite");
        send_addr(st, 1'b0, "R2 old high octets gone");
        load_station(st);
    endtask

    task automatic t_bcast();
        set_cfg(0, 1, 0, 0, '0, '0);
        send_addr(48'hFFFF_FFFF_FFFF, 1'b1, "R8 broadcast accepted");
        set_cfg(0, 0, 1, 0, '0, '0);
        send_addr(48'hFFFF_FFFF_FFFF, 1'b0, "R9 broadcast with empty table");
        set_cfg(0, 0, 1, 0, 32'(1) << ref_hash('1), '0);
        if (ref_hash('1) >= 6'd32) set_cfg(0, 0, 1, 0, '0, 32'(1) << (ref_hash('1) - 6'd32));
        send_addr(48'hFFFF_FFFF_FFFF, 1'b1, "R9 broadcast via hash bit");
    endtask

    task automatic t_hash();
        logic [47:0] glo, ghi;
        logic [5:0]  ilo, ihi;
        find_group(1'b0, glo);
        find_group(1'b1, ghi);
        ilo = ref_hash(glo);
        ihi = ref_hash(ghi);
        set_cfg(0, 0, 1, 0, 32'(1) << ilo, '0);
        send_addr(glo, 1'b1, "R6 low word bit hit");
        set_cfg(0, 0, 1, 0, ~(32'(1) << ilo), '1);
        send_addr(glo, 1'b0, "R6 low word bit clear");
        set_cfg(0, 0, 1, 0, '0, 32'(1) << (ihi - 6'd32));
        send_addr(ghi, 1'b1, "R6 high word bit hit");
        set_cfg(0, 0, 1, 0, '1, ~(32'(1) << (ihi - 6'd32)));
        send_addr(ghi, 1'b0, "R6 high word bit clear");
        set_cfg(1, 1, 0, 0, '1, '1);
        send_addr(glo, 1'b0, "R9 group needs mcast enable");
    endtask

    task automatic t_promisc();
        set_cfg(0, 0, 0, 1, '0, '0);
        send_addr(48'h12_34_56_78_9A_BC, 1'b1, "R10 promisc unicast");
        send_addr(48'h12_34_56_78_9A_BD, 1'b1, "R10 promisc group, empty table");
        set_cfg(1, 1, 1, 0, '1, '1);
        send_addr(48'h12_34_56_78_9A_BC, 1'b0, "R11 foreign unicast all paths on");
        set_cfg(0, 0, 0, 0, '1, '1);
        send_addr(48'hFFFF_FFFF_FFFF, 1'b0, "R11 nothing enabled");
    endtask

    task automatic t_framing();
        logic [47:0] st;
        st = 48'h66_55_44_33_22_10;
        set_cfg(1, 0, 0, 0, '0, '0);
        // Extra octets after the address must not raise a strobe.
        send_addr(st, 1'b1, "R3 address before payload");
        for (int k = 0; k < 8; k++) push(8'hFF, 1'b0);
        idle_cycle();
        check("R3 payload ignored", {31'd0, dec_valid}, 32'd0);
        // Restart in the middle of an address.
        push(8'hAB, 1'b1);
        push(8'hCD, 1'b0);
        push(8'hEF, 1'b0);
        send_addr(st, 1'b1, "R3 restart mid-address");
        // Gaps between octets are allowed.
        for (int k = 0; k < 6; k++) begin
            push(st[8*k +: 8], k == 0);
            idle_cycle();
            if (k < 5) check("R3 gap no strobe", {31'd0, dec_valid}, 32'd0);
        end
        check("R3 strobe after gapped octets", {31'd0, dec_valid}, 32'd1);
        check("R7 gapped match accept", {31'd0, dec_accept}, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_station();
        t_bcast();
        t_hash();
        t_promisc();
        t_framing();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule